// File: doc/BRIEF.md
# Sync Pulse Width Classifier

This block watches a single sync-level input from a composite video source and measures how long each sync pulse lasts, in clock cycles. When a pulse ends, its length is compared against two programmable limits. A long pulse is reported as a frame retrace and a medium pulse as a line retrace. Anything shorter is treated as noise and produces no event. Short pulses are typical of software toggling the sync level during tape activity.

Each line or frame event is a one-cycle strobe. The measured width of the most recent pulse is held on an output until the next pulse ends. The width counter stops at its largest value instead of wrapping. A very long pulse therefore still reads as long.

The two limits are taken from input pins into internal registers. The registers are loaded only on clock edges where sync is sampled inactive. A limit changed in the middle of a pulse does not affect that pulse. The event outputs form a valid-only stream with no back-pressure: a strobe is valid for exactly one cycle, and the consumer must accept it in that cycle.

Top module: `sync_width_classifier`

## Requirements
- R1: After reset, `line_evt` and `frame_evt` are 0, `pulse_width` is 0, the line limit is 15 and the frame limit is 1235.
- R2: A pulse's width is the number of consecutive rising clock edges at which `sync_in` is sampled 1. It is reported on `pulse_width` when the pulse ends.
- R3: A pulse whose width is at least the frame limit raises `frame_evt`. This check takes priority over the line check, even when the frame limit is below the line limit.
- R4: A pulse whose width is at least the line limit but below the frame limit raises `line_evt`. With the default limits, this covers widths 15 to 1234.
- R5: A pulse below both limits raises no strobe. At the default limits this includes widths 11 and 14. `pulse_width` is still updated.
- R6: Strobes are high in the single cycle after the first rising edge at which `sync_in` is sampled 0 following a pulse. At most one strobe is raised per pulse. Pulses separated by a one-cycle gap each produce their own result.
- R7: The width saturates at 2^CNT_W-1, which is 4095 by default, instead of wrapping.
- R8: The limit inputs are captured only on edges where `sync_in` is sampled 0. Changes made while sync is high have no effect on the pulse in progress.
- R9: `pulse_width` holds its value until the next pulse ends.
- R10: With the line limit lowered to 11, 11-cycle pulses raise `line_evt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_in | input | 1 | Sync level, 1 = sync asserted |
| line_thr_in | input | CNT_W | Minimum width for a line retrace |
| frame_thr_in | input | CNT_W | Minimum width for a frame retrace |
| line_evt | output | 1 | One-cycle line retrace strobe |
| frame_evt | output | 1 | One-cycle frame retrace strobe |
| pulse_width | output | CNT_W | Width of the most recent completed pulse |

## Verification
The strobes and the new width appear one clock after the first rising edge that samples `sync_in` low. The bench drives inputs on falling edges and reads outputs on the next falling edge after that capturing edge. A limit change takes effect from the first low-sampled edge onward, and the bench's reference model loads its own limits at the same edges. The model runs on every rising edge, and all three outputs are compared against it on every falling edge. Directed checks at pulse ends cover the boundary widths, saturation and limit changes made mid-pulse.

// File: rtl/sync_cls_pkg.sv
package sync_cls_pkg;
  typedef enum logic [1:0] {
    PK_NOISE = 2'd0,
    PK_LINE  = 2'd1,
    PK_FRAME = 2'd2
  } pulse_kind_e;

  // Frame check wins over line check
  function automatic pulse_kind_e judge_kind(input int unsigned w,
                                             input int unsigned line_thr,
                                             input int unsigned frame_thr);
    if (w >= frame_thr) return PK_FRAME;
    if (w >= line_thr)  return PK_LINE;
    return PK_NOISE;
  endfunction
endpackage

// File: rtl/sync_edge_track.sv
module sync_edge_track (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  output logic pulse_cont,
  output logic pulse_end,
  output logic idle
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_in;
  end

  assign pulse_cont = sync_in & prev_q;
  assign pulse_end  = ~sync_in & prev_q;
  assign idle       = ~sync_in;

  AST_END_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_end |-> $past(sync_in)); // R6
endmodule

// File: rtl/sat_width_counter.sv
module sat_width_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_in,
  input  logic             pulse_cont,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] MAX_CNT = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE     = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] nxt;

  always_comb begin
    nxt = count;
    if (sync_in) begin
      if (!pulse_cont)           nxt = ONE;
      else if (count != MAX_CNT) nxt = count + ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= nxt;
  end

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_in && pulse_cont && count == MAX_CNT) |=> (count == MAX_CNT)); // R7
  AST_FIRST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_in && !pulse_cont) |=> (count == ONE)); // R2
endmodule

// File: rtl/limit_regs.sv
module limit_regs #(
  parameter int CNT_W         = 12,
  parameter int LINE_DEFAULT  = 15,
  parameter int FRAME_DEFAULT = 1235
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle,
  input  logic [CNT_W-1:0] line_thr_in,
  input  logic [CNT_W-1:0] frame_thr_in,
  output logic [CNT_W-1:0] line_thr,
  output logic [CNT_W-1:0] frame_thr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_thr  <= CNT_W'(LINE_DEFAULT);
      frame_thr <= CNT_W'(FRAME_DEFAULT);
    end else if (idle) begin
      line_thr  <= line_thr_in;
      frame_thr <= frame_thr_in;
    end
  end

  AST_LIMIT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> ($stable(line_thr) && $stable(frame_thr))); // R8
endmodule

// File: rtl/pulse_judge.sv
module pulse_judge
  import sync_cls_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse_end,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] line_thr,
  input  logic [CNT_W-1:0] frame_thr,
  output logic             line_evt,
  output logic             frame_evt,
  output logic [CNT_W-1:0] pulse_width
);
  pulse_kind_e kind;

  always_comb kind = judge_kind(int'(count), int'(line_thr), int'(frame_thr));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_evt    <= 1'b0;
      frame_evt   <= 1'b0;
      pulse_width <= '0;
    end else begin
      line_evt  <= pulse_end && (kind == PK_LINE);
      frame_evt <= pulse_end && (kind == PK_FRAME);
      if (pulse_end) pulse_width <= count;
    end
  end

  AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({line_evt, frame_evt})); // R6
  AST_LINE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    line_evt |=> !line_evt); // R6
  AST_FRAME_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    frame_evt |=> !frame_evt); // R6
  AST_WIDTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse_end |=> $stable(pulse_width)); // R9
endmodule

// File: rtl/sync_width_classifier.sv
module sync_width_classifier #(
  parameter int CNT_W         = 12,
  parameter int LINE_DEFAULT  = 15,
  parameter int FRAME_DEFAULT = 1235
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_in,
  input  logic [CNT_W-1:0] line_thr_in,
  input  logic [CNT_W-1:0] frame_thr_in,
  output logic             line_evt,
  output logic             frame_evt,
  output logic [CNT_W-1:0] pulse_width
);
  logic             pulse_cont, pulse_end, idle;
  logic [CNT_W-1:0] count, line_thr, frame_thr;

  sync_edge_track u_edge (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in),
    .pulse_cont(pulse_cont), .pulse_end(pulse_end), .idle(idle)
  );

  sat_width_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in),
    .pulse_cont(pulse_cont), .count(count)
  );

  limit_regs #(.CNT_W(CNT_W), .LINE_DEFAULT(LINE_DEFAULT),
               .FRAME_DEFAULT(FRAME_DEFAULT)) u_lim (
    .clk(clk), .rst_n(rst_n), .idle(idle),
    .line_thr_in(line_thr_in), .frame_thr_in(frame_thr_in),
    .line_thr(line_thr), .frame_thr(frame_thr)
  );

  pulse_judge #(.CNT_W(CNT_W)) u_judge (
    .clk(clk), .rst_n(rst_n), .pulse_end(pulse_end), .count(count),
    .line_thr(line_thr), .frame_thr(frame_thr),
    .line_evt(line_evt), .frame_evt(frame_evt), .pulse_width(pulse_width)
  );

  AST_STROBE_NEEDS_END: assert property (@(posedge clk) disable iff (!rst_n)
    (line_evt || frame_evt) |-> $past(pulse_end)); // R6
endmodule

// File: tb/tb_sync_width_classifier.sv
module tb_sync_width_classifier;
  localparam int CNT_W = 12;
  localparam int MAXW  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_in = 1'b0;
  logic [CNT_W-1:0] line_thr_in  = 12'd15;
  logic [CNT_W-1:0] frame_thr_in = 12'd1235;
  logic line_evt, frame_evt;
  logic [CNT_W-1:0] pulse_width;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  sync_width_classifier #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in),
    .line_thr_in(line_thr_in), .frame_thr_in(frame_thr_in),
    .line_evt(line_evt), .frame_evt(frame_evt), .pulse_width(pulse_width)
  );

  // Behavioural reference model
  int m_run, m_th, m_tv, m_w;
  bit m_prev, m_h, m_v;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_prev = 0; m_h = 0; m_v = 0; m_w = 0;
      m_th = 15; m_tv = 1235;
    end else begin
      m_h = 0; m_v = 0;
      if (sync_in) m_run = m_prev ? m_run + 1 : 1;
      if (!sync_in && m_prev) begin
        m_w = (m_run > MAXW) ? MAXW : m_run;
        if (m_w >= m_tv) m_v = 1;
        else if (m_w >= m_th) m_h = 1;
      end
      if (!sync_in) begin
        m_th = int'(line_thr_in);
        m_tv = int'(frame_thr_in);
      end
      m_prev = sync_in;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check("R6 per-cycle line_evt", int'(line_evt), int'(m_h));
      check("R3 per-cycle frame_evt", int'(frame_evt), int'(m_v));
      check("R9 per-cycle pulse_width", int'(pulse_width), m_w);
    end
  end

  // Drive a pulse of len cycles; return just after the result is visible
  task automatic pulse(input int len);
    sync_in = 1'b1;
    repeat (len) @(negedge clk);
    sync_in = 1'b0;
    @(negedge clk);
  endtask

  task automatic expect_res(input string tag, input int h, input int v, input int w);
    check(tag, int'(line_evt), h);
    check(tag, int'(frame_evt), v);
    check(tag, int'(pulse_width), w);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 line_evt reset", int'(line_evt), 0);
    check("R1 frame_evt reset", int'(frame_evt), 0);
    check("R1 pulse_width reset", int'(pulse_width), 0);
    rst_n = 1'b1;
    @(negedge clk);

    pulse(11); expect_res("R5 width 11 noise", 0, 0, 11);
    @(negedge clk); check("R2 width 11 kept", int'(pulse_width), 11);
    pulse(16); expect_res("R4 width 16 line", 1, 0, 16);
    @(negedge clk); check("R6 strobe one cycle", int'(line_evt), 0);
    pulse(15); expect_res("R4 width 15 boundary", 1, 0, 15);
    pulse(14); expect_res("R5 width 14 noise", 0, 0, 14);
    pulse(27); expect_res("R2 width 27", 1, 0, 27);
    pulse(1234); expect_res("R4 width 1234 line", 1, 0, 1234);
    pulse(1235); expect_res("R3 width 1235 frame", 0, 1, 1235);
    repeat (20) @(negedge clk);
    check("R9 width held", int'(pulse_width), 1235);

    // Back-to-back with a one-cycle gap
    sync_in = 1'b1; repeat (16) @(negedge clk);
    sync_in = 1'b0; @(negedge clk);
    sync_in = 1'b1; check("R6 first of pair", int'(line_evt), 1);
    repeat (19) @(negedge clk);
    sync_in = 1'b0; @(negedge clk);
    expect_res("R6 second of pair", 1, 0, 19);

    // Limit change during a pulse is not used for that pulse
    sync_in = 1'b1; @(negedge clk);
    line_thr_in = 12'd11;
    repeat (10) @(negedge clk);
    sync_in = 1'b0; @(negedge clk);
    expect_res("R8 mid-pulse change ignored", 0, 0, 11);
    @(negedge clk);
    pulse(11); expect_res("R10 lowered limit 11", 1, 0, 11);
    pulse(10); expect_res("R10 width 10 still noise", 0, 0, 10);

    pulse(5000); expect_res("R7 saturation", 0, 1, MAXW);
    @(negedge clk);

    // Frame limit below line limit: frame wins
    line_thr_in = 12'd20; frame_thr_in = 12'd10;
    @(negedge clk);
    pulse(12); expect_res("R3 frame priority", 0, 1, 12);
    pulse(9); expect_res("R5 below both", 0, 0, 9);
    line_thr_in = 12'd15; frame_thr_in = 12'd1235;
    repeat (2) @(negedge clk);
    pulse(1); expect_res("R2 single-cycle pulse", 0, 0, 1);
    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule